// File: doc/BRIEF.md
# Cache Inquire Snoop Responder

This block answers snoop (inquire) requests from other bus masters. It checks each request against a small tag store that stands in for an instruction cache and a data cache. A request starts when the active-low inquire strobe is sampled low at a rising clock edge. The address presented with it is split into a tag, a line index and a byte offset. On the second rising edge after the strobe is sampled, the block drives two active-low status outputs. `hit_n` reports whether either cache holds a valid copy of the line. `hitm_n` reports whether the data cache holds the line in the modified state.

A hit to a modified line keeps `hitm_n` low until the surrounding system reports that the line has been written back. The line's data-cache state then drops to invalid or shared, as the system requests. Line states are loaded through a simple update port. A strobe that arrives while an inquire is still in flight is dropped, and a sticky protocol-error flag records it.

Top module: `snoop_responder`

## Requirements
- R1: While reset is asserted, and after it is released until the first completed inquire, `hit_n` and `hitm_n` are high and `proto_err` is low.
- R2: An inquire whose tag matches a data line in state S (01), E (10) or M (11), or a valid instruction line, drives `hit_n` low at the second rising edge after the strobe is sampled. Before that edge, `hit_n` keeps its old value.
- R3: An inquire that matches no valid line in either cache drives `hit_n` high at that same second edge.
- R4: `hit_n` changes only at the completion edge of an accepted inquire. It holds between inquiries, including while the tag store is rewritten.
- R5: `hitm_n` goes low at the completion edge only when the matching data line is in state M (11). Otherwise it is driven high at that edge.
- R6: Once low, `hitm_n` stays low until `wb_done` is sampled high. It returns high at that same edge.
- R7: When the write-back is reported, the data line that caused the hit moves to state I (00) if `inv_req` is 1, and to state S (01) if `inv_req` is 0.
- R8: A strobe sampled low while an inquire is pending is ignored. Pending means within the two cycles after an accepted strobe, or while `hitm_n` is low. Such a strobe sets `proto_err`, which stays set until reset.
- R9: `wb_done` sampled high while `hitm_n` is high has no effect on any line state.
- R10: When `upd_en` is high, the update port writes the tag and state of the line at the addressed index. `upd_sel_data`=1 selects the data cache. `upd_sel_data`=0 selects the instruction cache, where any non-zero state means valid.
- R11: A hit in the instruction cache alone never drives `hitm_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inq_strobe_n | input | 1 | Active-low inquire strobe |
| inq_addr | input | ADDR_W | Inquire address |
| upd_en | input | 1 | Tag-store write enable |
| upd_sel_data | input | 1 | 1 = data cache, 0 = instruction cache |
| upd_addr | input | ADDR_W | Address of the line to write |
| upd_state | input | 2 | Line state: I=00, S=01, E=10, M=11 |
| wb_done | input | 1 | Write-back of the modified line is complete |
| inv_req | input | 1 | On write-back: 1 = invalidate line, 0 = make shared |
| hit_n | output | 1 | Active-low inquire hit |
| hitm_n | output | 1 | Active-low hit to a modified data line |
| proto_err | output | 1 | Sticky flag for an ignored overlapping strobe |

## Verification
The bench sweeps every line index through every data state and both instruction-valid settings, with matching and mismatching tags. It samples before and after the completion edge, so a design that answers one cycle early or one cycle late fails the hold checks. Every modified hit is followed by a write-back with invalidate and with share. A second inquire to the same line then exposes a design that leaves the line modified or picks the wrong new state. The remaining tests cover the overlap cases. A strobe one cycle behind another, a strobe while `hitm_n` is held, and a `wb_done` pulse with no modified hit outstanding must each leave the outputs and line states alone. A design that accepted any of them would show a changed output or an extra `hitm_n`.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
   typedef enum logic [1:0] {
      ST_INV = 2'b00,
      ST_SHR = 2'b01,
      ST_EXC = 2'b10,
      ST_MOD = 2'b11
   } line_state_e;
endpackage

// File: rtl/snoop_tag_array.sv
module snoop_tag_array #(
   parameter int IDX_W = 4,
   parameter int TAG_W = 23,
   parameter int ST_W  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [ST_W-1:0]  wr_st,
   input  logic             st_en,
   input  logic [IDX_W-1:0] st_idx,
   input  logic [ST_W-1:0]  st_val,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [ST_W-1:0]  rd_st
);
   localparam int DEPTH = 1 << IDX_W;

   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [ST_W-1:0]  st_q  [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q[g]  <= '0;
            tag_q[g] <= '0;
         end else begin
            if (wr_en && wr_idx == IDX_W'(g)) begin
               tag_q[g] <= wr_tag;
               st_q[g]  <= wr_st;
            end
            if (st_en && st_idx == IDX_W'(g))
               st_q[g] <= st_val;
         end
      end
   end

   assign rd_st  = st_q[rd_idx];
   assign rd_hit = (rd_st != '0) && (tag_q[rd_idx] == rd_tag);
endmodule

// File: rtl/snoop_resp_ctrl.sv
module snoop_resp_ctrl
   import snoop_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int TAG_W = 23
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_n,
   input  logic [IDX_W-1:0] req_idx,
   input  logic [TAG_W-1:0] req_tag,
   output logic [IDX_W-1:0] lk_idx,
   output logic [TAG_W-1:0] lk_tag,
   input  logic             d_hit,
   input  logic [1:0]       d_st,
   input  logic             i_hit,
   input  logic             wb_done,
   input  logic             inv_req,
   output logic             wb_en,
   output logic [IDX_W-1:0] wb_idx,
   output logic [1:0]       wb_st,
   output logic             hit_n,
   output logic             hitm_n,
   output logic             proto_err
);
   logic             s1_vld, s2_vld, s2_hit, s2_mod;
   logic [IDX_W-1:0] s2_idx;
   logic             busy, take;

   assign busy = s1_vld | s2_vld | ~hitm_n;
   assign take = ~strobe_n & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld    <= 1'b0;
         s2_vld    <= 1'b0;
         s2_hit    <= 1'b0;
         s2_mod    <= 1'b0;
         s2_idx    <= '0;
         lk_idx    <= '0;
         lk_tag    <= '0;
         wb_idx    <= '0;
         hit_n     <= 1'b1;
         hitm_n    <= 1'b1;
         proto_err <= 1'b0;
      end else begin
         s1_vld <= take;
         if (take) begin
            lk_idx <= req_idx;
            lk_tag <= req_tag;
         end
         s2_vld <= s1_vld;
         if (s1_vld) begin
            s2_hit <= d_hit | i_hit;
            s2_mod <= d_hit && (d_st == ST_MOD);
            s2_idx <= lk_idx;
         end
         if (s2_vld) begin
            hit_n  <= ~s2_hit;
            hitm_n <= ~s2_mod;
            if (s2_mod) wb_idx <= s2_idx;
         end else if (!hitm_n && wb_done) begin
            hitm_n <= 1'b1;
         end
         if (!strobe_n && busy) proto_err <= 1'b1;
      end
   end

   assign wb_en = ~hitm_n & wb_done;
   assign wb_st = inv_req ? ST_INV : ST_SHR;
endmodule

// File: rtl/snoop_responder.sv
module snoop_responder #(
   parameter int ADDR_W   = 32,
   parameter int OFF_W    = 5,
   parameter int IDX_W    = 4,
   parameter bit ICACHE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inq_strobe_n,
   input  logic [ADDR_W-1:0] inq_addr,
   input  logic              upd_en,
   input  logic              upd_sel_data,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [1:0]        upd_state,
   input  logic              wb_done,
   input  logic              inv_req,
   output logic              hit_n,
   output logic              hitm_n,
   output logic              proto_err
);
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

   if (TAG_W < 1) begin : g_bad_tag
      $error("snoop_responder: ADDR_W too small for OFF_W + IDX_W");
   end
   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("snoop_responder: IDX_W out of range");
   end
   if (OFF_W < 0) begin : g_bad_off
      $error("snoop_responder: OFF_W negative");
   end

   logic [IDX_W-1:0] lk_idx, wb_idx, u_idx;
   logic [TAG_W-1:0] lk_tag, u_tag;
   logic             d_hit, i_hit, wb_en;
   logic [1:0]       d_st, wb_st;

   assign u_idx = upd_addr[OFF_W +: IDX_W];
   assign u_tag = upd_addr[ADDR_W-1 -: TAG_W];

   snoop_resp_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .strobe_n(inq_strobe_n),
      .req_idx(inq_addr[OFF_W +: IDX_W]),
      .req_tag(inq_addr[ADDR_W-1 -: TAG_W]),
      .lk_idx(lk_idx), .lk_tag(lk_tag),
      .d_hit(d_hit), .d_st(d_st), .i_hit(i_hit),
      .wb_done(wb_done), .inv_req(inv_req),
      .wb_en(wb_en), .wb_idx(wb_idx), .wb_st(wb_st),
      .hit_n(hit_n), .hitm_n(hitm_n), .proto_err(proto_err)
   );

   snoop_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ST_W(2)) u_dcache (
      .clk(clk), .rst_n(rst_n),
      .wr_en(upd_en & upd_sel_data), .wr_idx(u_idx), .wr_tag(u_tag), .wr_st(upd_state),
      .st_en(wb_en), .st_idx(wb_idx), .st_val(wb_st),
      .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_hit(d_hit), .rd_st(d_st)
   );

   if (ICACHE_EN) begin : g_icache
      logic i_st_unused;
      snoop_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .ST_W(1)) u_icache (
         .clk(clk), .rst_n(rst_n),
         .wr_en(upd_en & ~upd_sel_data), .wr_idx(u_idx), .wr_tag(u_tag),
         .wr_st(|upd_state),
         .st_en(1'b0), .st_idx('0), .st_val(1'b0),
         .rd_idx(lk_idx), .rd_tag(lk_tag), .rd_hit(i_hit), .rd_st(i_st_unused)
      );
   end else begin : g_no_icache
      assign i_hit = 1'b0;
   end
endmodule

// File: rtl/snoop_responder_chk.sv
module snoop_responder_chk (
   input logic clk,
   input logic rst_n,
   input logic inq_strobe_n,
   input logic wb_done,
   input logic hit_n,
   input logic hitm_n,
   input logic proto_err
);
   logic c1, c2, busy, acc;
   assign busy = c1 | c2 | ~hitm_n;
   assign acc  = ~inq_strobe_n & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c1 <= 1'b0;
         c2 <= 1'b0;
      end else begin
         c1 <= acc;
         c2 <= c1;
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (hit_n && hitm_n && !proto_err));

   assert_hit_only_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(hit_n) |-> $past(c2));

   assert_hitm_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hitm_n && !wb_done) |=> !hitm_n);

   assert_hitm_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hitm_n && wb_done) |=> hitm_n);

   assert_hitm_implies_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hitm_n) |-> !hit_n);

   assert_overlap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!inq_strobe_n && busy) |=> proto_err);

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);
endmodule

bind snoop_responder snoop_responder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .inq_strobe_n(inq_strobe_n), .wb_done(wb_done),
   .hit_n(hit_n), .hitm_n(hitm_n), .proto_err(proto_err)
);

// File: tb/snoop_responder_test.sv
module snoop_responder_test;
   localparam int ADDR_W = 32;
   localparam int OFF_W  = 5;
   localparam int IDX_W  = 4;
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              inq_strobe_n = 1'b1;
   logic [ADDR_W-1:0] inq_addr = '0;
   logic              upd_en = 1'b0;
   logic              upd_sel_data = 1'b0;
   logic [ADDR_W-1:0] upd_addr = '0;
   logic [1:0]        upd_state = '0;
   logic              wb_done = 1'b0;
   logic              inv_req = 1'b0;
   logic              hit_n, hitm_n, proto_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   snoop_responder #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) uut (
      .clk(clk), .rst_n(rst_n), .inq_strobe_n(inq_strobe_n), .inq_addr(inq_addr),
      .upd_en(upd_en), .upd_sel_data(upd_sel_data), .upd_addr(upd_addr),
      .upd_state(upd_state), .wb_done(wb_done), .inv_req(inv_req),
      .hit_n(hit_n), .hitm_n(hitm_n), .proto_err(proto_err)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [ADDR_W-1:0] mk(logic [TAG_W-1:0] t, int idx);
      return {t, IDX_W'(idx), {OFF_W{1'b0}}};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 hit_n in reset", hit_n, 1);
      check("R1 hitm_n in reset", hitm_n, 1);
      check("R1 proto_err in reset", proto_err, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic load(bit sel_d, logic [ADDR_W-1:0] a, logic [1:0] st);
      @(negedge clk);
      upd_en = 1'b1; upd_sel_data = sel_d; upd_addr = a; upd_state = st;
      @(negedge clk);
      upd_en = 1'b0;
   endtask

   // drives one inquire, checks the hold before the completion edge and the result after
   task automatic inquire(logic [ADDR_W-1:0] a, bit exp_hit, bit exp_hitm, string req);
      logic old_hit, old_hitm;
      @(negedge clk);
      old_hit = hit_n; old_hitm = hitm_n;
      inq_strobe_n = 1'b0; inq_addr = a;
      @(negedge clk);
      inq_strobe_n = 1'b1;
      check("R2 hold after strobe edge", hit_n, old_hit);
      @(negedge clk);
      check("R4 hold one cycle later", hit_n, old_hit);
      check("R5 hitm hold one cycle later", hitm_n, old_hitm);
      @(negedge clk);
      check({req, " hit_n"}, hit_n, !exp_hit);
      check({req, " hitm_n"}, hitm_n, !exp_hitm);
   endtask

   task automatic writeback(bit inv);
      @(negedge clk);
      check("R6 hitm held before wb_done", hitm_n, 0);
      wb_done = 1'b1; inv_req = inv;
      @(negedge clk);
      wb_done = 1'b0;
      check("R6 hitm released on wb_done", hitm_n, 1);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      logic [TAG_W-1:0] t;
      bit exp_hit;
      do_reset();

      // R2 R3 R5 R7 R10 R11: sweep every index, data state and instruction validity
      for (int idx = 0; idx < (1 << IDX_W); idx++) begin
         for (int st = 0; st < 4; st++) begin
            for (int iv = 0; iv < 2; iv++) begin
               t = TAG_W'(32'h1a2b + idx * 97 + st * 13 + iv);
               load(1'b1, mk(t, idx), 2'(st));
               load(1'b0, mk(t, idx), iv ? 2'b10 : 2'b00);
               exp_hit = (st != 0) || (iv != 0);
               inquire(mk(t, idx), exp_hit, st == 3, "R2 R3 R5 R10 R11 match");
               if (st == 3) begin
                  writeback((idx + iv) % 2 == 1);
                  inquire(mk(t, idx), ((idx + iv) % 2 == 0) || (iv != 0), 1'b0,
                          "R7 state after write-back");
               end
               inquire(mk(t ^ 1'b1, idx), 1'b0, 1'b0, "R3 tag mismatch");
            end
         end
      end

      // R4: rewriting the tag store between inquiries leaves hit_n alone
      load(1'b1, mk(TAG_W'(5), 2), 2'b01);
      inquire(mk(TAG_W'(5), 2), 1'b1, 1'b0, "R2 setup");
      load(1'b1, mk(TAG_W'(5), 2), 2'b00);
      repeat (3) @(negedge clk);
      check("R4 hit_n holds over update", hit_n, 0);

      // R9: wb_done without an outstanding modified hit changes nothing
      load(1'b1, mk(TAG_W'(9), 7), 2'b11);
      @(negedge clk);
      wb_done = 1'b1; inv_req = 1'b1;
      @(negedge clk);
      wb_done = 1'b0;
      inquire(mk(TAG_W'(9), 7), 1'b1, 1'b1, "R9 line still modified");

      // R8: strobe while hitm_n held is ignored and flagged
      check("R8 flag clear before overlap", proto_err, 0);
      @(negedge clk);
      inq_strobe_n = 1'b0; inq_addr = mk(TAG_W'(77), 1);
      @(negedge clk);
      inq_strobe_n = 1'b1;
      check("R8 flag set by strobe during hitm", proto_err, 1);
      repeat (3) @(negedge clk);
      check("R8 hit_n unchanged by ignored strobe", hit_n, 0);
      check("R8 hitm_n unchanged by ignored strobe", hitm_n, 0);
      writeback(1'b1);
      inquire(mk(TAG_W'(9), 7), 1'b0, 1'b0, "R7 invalidated line misses");
      check("R8 flag sticky", proto_err, 1);

      // R8: strobe one cycle behind an accepted one
      do_reset();
      load(1'b1, mk(TAG_W'(3), 4), 2'b11);
      @(negedge clk);
      inq_strobe_n = 1'b0; inq_addr = mk(TAG_W'(8), 4);
      @(negedge clk);
      inq_addr = mk(TAG_W'(3), 4);
      @(negedge clk);
      inq_strobe_n = 1'b1;
      check("R8 flag after back-to-back strobe", proto_err, 1);
      @(negedge clk);
      check("R8 first inquire wins hit_n", hit_n, 1);
      check("R8 first inquire wins hitm_n", hitm_n, 1);
      repeat (3) @(negedge clk);
      check("R8 second strobe never answered", hitm_n, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule